// File: doc/BRIEF.md
# Dual-bank tightly coupled RAM arbiter

This block puts a 16 KB single-cycle on-chip RAM behind three requesters: an instruction fetch port, a processor data port and an external port for other bus masters, which is handled like a DMA transfer. The storage is built as two independent 8 KB banks. Each bank accepts one access per clock, so a fetch and a data access that land in different banks both complete in the same cycle.

The 64 KB byte address space seen by the ports has two windows onto the same storage. The lower half (0x0000 to 0x7FFF) is the instruction view and the upper half (0x8000 to 0xFFFF) is the data view. The instruction port uses the lower view and the data port the upper one. The external port can use either view, because both resolve to the same words.

Each port raises a request and holds it until its ready output is high in the same cycle. That cycle is the grant. Read data appears on the port one cycle later. The data port has priority over the instruction port. The external port has the lowest priority, but a bounded wait counter guarantees that it is granted after a fixed number of lost cycles.

Top module: `tcm_dual_bank`

## Requirements
- R1: After reset, with no request raised, all three ready outputs are low.
- R2: The word is selected by byte address bits [13:2]. Bit 13 picks the bank (0 gives bank 0, 1 gives bank 1) and bits [12:2] pick the word within that bank. Bits 15, 14, 1 and 0 do not change which word is addressed (for example, instruction address 0x4000 reads the same word as 0x0000).
- R3: A word written by the data port at 0x8000 + X is read back by the instruction port at X.
- R4: When the instruction and data ports both request, their addresses fall in different banks, and the external port is idle, both ready outputs are high in that cycle.
- R5: When the instruction and data ports request the same bank, the data port is ready and the instruction port is not. The instruction port is served in a later cycle, and it sees any write the data port made in between.
- R6: When the external port is not yet due under R7, it is not ready while the data port or the instruction port requests the same bank. It is ready in any cycle where its bank has no other requester, including cycles where the other bank is busy.
- R7: The external port loses at most 4 consecutive cycles while requesting. On the 5th cycle it is granted, even over the data port.
- R8: Through the external port, address X in the instruction view (bit 15 = 0) and X + 0x8000 in the data view reach the same word that the other two ports use.
- R9: Read data for a grant is on the port's read-data output in the cycle after the one where ready was high.
- R10: Byte enable bit i (write ports, 4 bits) writes data bits [8i+7:8i]. Bytes whose enable is low keep their old value.
- R11: Under mixed random traffic on all three ports, every read returns the value the last granted write left in that word.
- R12: A ready output is never high while its own request is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously to clk |
| ip_req | input | 1 | Instruction port request |
| ip_addr | input | 16 | Instruction port byte address |
| ip_rdy | output | 1 | Instruction port granted this cycle |
| ip_rdata | output | 32 | Instruction read data, one cycle after grant |
| dp_req | input | 1 | Data port request |
| dp_we | input | 1 | Data port write (1) or read (0) |
| dp_be | input | 4 | Data port byte enables |
| dp_addr | input | 16 | Data port byte address |
| dp_wdata | input | 32 | Data port write data |
| dp_rdy | output | 1 | Data port granted this cycle |
| dp_rdata | output | 32 | Data port read data, one cycle after grant |
| xp_req | input | 1 | External port request |
| xp_we | input | 1 | External port write (1) or read (0) |
| xp_be | input | 4 | External port byte enables |
| xp_addr | input | 16 | External port byte address, either view |
| xp_wdata | input | 32 | External port write data |
| xp_rdy | output | 1 | External port granted this cycle |
| xp_rdata | output | 32 | External port read data, one cycle after grant |

## Verification
The bench targets bank selection on bit 13 and aliasing across bits 14 and 15. A decoder that used the wrong bit would read back a neighbour's data, or would fail to serve a fetch and a data access in parallel. In a same-bank collision the bench checks both that the data port wins and that the delayed fetch sees the fresh write; a swapped priority or a stale read return shows up at once. It holds the data port busy on the external port's bank and counts the lost cycles exactly. A counter that is off by one, or that never overrides the data port, shifts the grant cycle. Partial byte writes and a long random run against a reference memory expose a wrong byte lane or a read-data mux that follows the wrong bank.

// File: rtl/tcm_pkg.sv
package tcm_pkg;

  // Geometry of the tightly coupled RAM
  localparam int unsigned TCM_ADDR_W     = 16;
  localparam int unsigned TCM_DATA_W     = 32;
  localparam int unsigned TCM_BANKS      = 2;
  localparam int unsigned TCM_BANK_WORDS = 2048;

  // Derived widths
  localparam int unsigned TCM_BE_W   = TCM_DATA_W / 8;
  localparam int unsigned TCM_BYTE_W = $clog2(TCM_BE_W);
  localparam int unsigned TCM_WORD_W = $clog2(TCM_BANK_WORDS);
  localparam int unsigned TCM_BANK_W = (TCM_BANKS > 1) ? $clog2(TCM_BANKS) : 1;
  localparam int unsigned TCM_BANK_LSB = TCM_BYTE_W + TCM_WORD_W;

  // Requesters, in index order
  localparam int unsigned TCM_PORTS = 3;
  localparam int unsigned PORT_IP   = 0;
  localparam int unsigned PORT_DP   = 1;
  localparam int unsigned PORT_XP   = 2;

  // One access as presented to a bank
  typedef struct packed {
    logic                    we;
    logic [TCM_BE_W-1:0]     be;
    logic [TCM_WORD_W-1:0]   word;
    logic [TCM_DATA_W-1:0]   wdata;
  } tcm_acc_t;

endpackage

// File: rtl/tcm_addr_map.sv
module tcm_addr_map
  import tcm_pkg::*;
(
  input  logic                  req,
  input  logic [TCM_ADDR_W-1:0] addr,
  output logic [TCM_BANK_W-1:0] bank,
  output logic [TCM_WORD_W-1:0] word,
  output logic [TCM_BANKS-1:0]  hit
);

  // Offset within the window: the view bits and the byte lane do not select storage
  assign word = addr[TCM_BYTE_W +: TCM_WORD_W];
  assign bank = addr[TCM_BANK_LSB +: TCM_BANK_W];

  logic unused_view_bits;
  assign unused_view_bits = ^{addr[TCM_ADDR_W-1:TCM_BANK_LSB+TCM_BANK_W], addr[TCM_BYTE_W-1:0]};

  for (genvar b = 0; b < TCM_BANKS; b++) begin : g_hit
    assign hit[b] = req && (bank == TCM_BANK_W'(b));
  end

endmodule

// File: rtl/tcm_bank_arb.sv
module tcm_bank_arb
  import tcm_pkg::*;
(
  input  logic                           xp_urgent,
  input  logic [TCM_PORTS-1:0]           hit,
  input  tcm_acc_t [TCM_PORTS-1:0]       acc,
  output logic [TCM_PORTS-1:0]           gnt,
  output logic                           en,
  output tcm_acc_t                       sel
);

  // Fixed order: overdue external, data, instruction, external
  always_comb begin
    gnt = '0;
    if (hit[PORT_XP] && xp_urgent) begin
      gnt[PORT_XP] = 1'b1;
    end else if (hit[PORT_DP]) begin
      gnt[PORT_DP] = 1'b1;
    end else if (hit[PORT_IP]) begin
      gnt[PORT_IP] = 1'b1;
    end else if (hit[PORT_XP]) begin
      gnt[PORT_XP] = 1'b1;
    end
  end

  assign en = |gnt;

  always_comb begin
    sel = '0;
    for (int p = 0; p < TCM_PORTS; p++) begin
      if (gnt[p]) sel = acc[p];
    end
  end

endmodule

// File: rtl/tcm_bank_ram.sv
module tcm_bank_ram
  import tcm_pkg::*;
(
  input  logic                  clk,
  input  logic                  en,
  input  tcm_acc_t              acc,
  output logic [TCM_DATA_W-1:0] q
);

  logic [TCM_DATA_W-1:0] mem [TCM_BANK_WORDS];

  // Single port: one write or one read per clock, read data registered
  always_ff @(posedge clk) begin
    if (en) begin
      if (acc.we) begin
        for (int i = 0; i < TCM_BE_W; i++) begin
          if (acc.be[i]) mem[acc.word][8*i +: 8] <= acc.wdata[8*i +: 8];
        end
      end else begin
        q <= mem[acc.word];
      end
    end
  end

endmodule

// File: rtl/tcm_xp_guard.sv
module tcm_xp_guard #(
  parameter int unsigned MAX_WAIT = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic xp_req,
  input  logic xp_gnt,
  output logic urgent
);

  localparam int unsigned LW = $clog2(MAX_WAIT + 1);

  logic [LW-1:0] lost_q, lost_d;
  logic          lost_en;

  always_comb begin
    lost_d = '0;
    if (xp_req && !xp_gnt) begin
      lost_d = (lost_q == LW'(MAX_WAIT)) ? lost_q : lost_q + 1'b1;
    end
  end

  assign lost_en = xp_req || (lost_q != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lost_q <= '0;
    end else if (lost_en) begin
      lost_q <= lost_d;
    end
  end

  assign urgent = (lost_q == LW'(MAX_WAIT));

endmodule

// File: rtl/tcm_dual_bank.sv
module tcm_dual_bank
  import tcm_pkg::*;
#(
  parameter int unsigned XP_MAX_WAIT = 4
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  ip_req,
  input  logic [TCM_ADDR_W-1:0] ip_addr,
  output logic                  ip_rdy,
  output logic [TCM_DATA_W-1:0] ip_rdata,
  input  logic                  dp_req,
  input  logic                  dp_we,
  input  logic [TCM_BE_W-1:0]   dp_be,
  input  logic [TCM_ADDR_W-1:0] dp_addr,
  input  logic [TCM_DATA_W-1:0] dp_wdata,
  output logic                  dp_rdy,
  output logic [TCM_DATA_W-1:0] dp_rdata,
  input  logic                  xp_req,
  input  logic                  xp_we,
  input  logic [TCM_BE_W-1:0]   xp_be,
  input  logic [TCM_ADDR_W-1:0] xp_addr,
  input  logic [TCM_DATA_W-1:0] xp_wdata,
  output logic                  xp_rdy,
  output logic [TCM_DATA_W-1:0] xp_rdata
);

  logic [TCM_PORTS-1:0]  p_req;
  logic [TCM_ADDR_W-1:0] p_addr [TCM_PORTS];
  logic [TCM_BANK_W-1:0] p_bank [TCM_PORTS];
  logic [TCM_WORD_W-1:0] p_word [TCM_PORTS];
  logic [TCM_BANKS-1:0]  p_hit  [TCM_PORTS];
  tcm_acc_t [TCM_PORTS-1:0] p_acc;
  logic [TCM_PORTS-1:0]  p_rdy;
  logic [TCM_BANK_W-1:0] rsel_q [TCM_PORTS];
  logic [TCM_DATA_W-1:0] p_rdata [TCM_PORTS];

  logic [TCM_PORTS-1:0]  b_gnt [TCM_BANKS];
  logic [TCM_DATA_W-1:0] b_q   [TCM_BANKS];
  logic                  xp_urgent;

  assign p_req            = {xp_req, dp_req, ip_req};
  assign p_addr[PORT_IP]  = ip_addr;
  assign p_addr[PORT_DP]  = dp_addr;
  assign p_addr[PORT_XP]  = xp_addr;

  // Access descriptors; the fetch port only reads
  always_comb begin
    p_acc[PORT_IP]       = '0;
    p_acc[PORT_IP].word  = p_word[PORT_IP];
    p_acc[PORT_DP].we    = dp_we;
    p_acc[PORT_DP].be    = dp_be;
    p_acc[PORT_DP].word  = p_word[PORT_DP];
    p_acc[PORT_DP].wdata = dp_wdata;
    p_acc[PORT_XP].we    = xp_we;
    p_acc[PORT_XP].be    = xp_be;
    p_acc[PORT_XP].word  = p_word[PORT_XP];
    p_acc[PORT_XP].wdata = xp_wdata;
  end

  for (genvar p = 0; p < TCM_PORTS; p++) begin : g_port
    tcm_addr_map u_map (
      .req  (p_req[p]),
      .addr (p_addr[p]),
      .bank (p_bank[p]),
      .word (p_word[p]),
      .hit  (p_hit[p])
    );
  end

  for (genvar b = 0; b < TCM_BANKS; b++) begin : g_bank
    logic [TCM_PORTS-1:0] hit;
    logic                 en;
    tcm_acc_t             sel;

    for (genvar p = 0; p < TCM_PORTS; p++) begin : g_col
      assign hit[p] = p_hit[p][b];
    end

    tcm_bank_arb u_arb (
      .xp_urgent (xp_urgent),
      .hit       (hit),
      .acc       (p_acc),
      .gnt       (b_gnt[b]),
      .en        (en),
      .sel       (sel)
    );

    tcm_bank_ram u_ram (
      .clk (clk),
      .en  (en),
      .acc (sel),
      .q   (b_q[b])
    );
  end

  always_comb begin
    p_rdy = '0;
    for (int b = 0; b < TCM_BANKS; b++) begin
      p_rdy = p_rdy | b_gnt[b];
    end
  end

  tcm_xp_guard #(.MAX_WAIT(XP_MAX_WAIT)) u_guard (
    .clk    (clk),
    .rst_n  (rst_n),
    .xp_req (xp_req),
    .xp_gnt (p_rdy[PORT_XP]),
    .urgent (xp_urgent)
  );

  // Remember which bank each grant used so the next cycle returns its data
  for (genvar p = 0; p < TCM_PORTS; p++) begin : g_ret
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        rsel_q[p] <= '0;
      end else if (p_rdy[p]) begin
        rsel_q[p] <= p_bank[p];
      end
    end
    assign p_rdata[p] = b_q[rsel_q[p]];
  end

  assign ip_rdy   = p_rdy[PORT_IP];
  assign dp_rdy   = p_rdy[PORT_DP];
  assign xp_rdy   = p_rdy[PORT_XP];
  assign ip_rdata = p_rdata[PORT_IP];
  assign dp_rdata = p_rdata[PORT_DP];
  assign xp_rdata = p_rdata[PORT_XP];

endmodule

// File: rtl/tcm_dual_bank_chk.sv
module tcm_dual_bank_chk
  import tcm_pkg::*;
#(
  parameter int unsigned MAX_WAIT = 4
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  ip_req,
  input logic                  ip_rdy,
  input logic                  dp_req,
  input logic                  dp_rdy,
  input logic                  xp_req,
  input logic                  xp_rdy,
  input logic [TCM_BANK_W-1:0] ip_bank,
  input logic [TCM_BANK_W-1:0] dp_bank,
  input logic [TCM_BANK_W-1:0] xp_bank
);

  localparam int unsigned LW = $clog2(MAX_WAIT + 2);

  // Independent count of consecutive external losses
  logic [LW-1:0] lost_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lost_q <= '0;
    end else if (xp_req && !xp_rdy) begin
      if (lost_q != '1) lost_q <= lost_q + 1'b1;
    end else begin
      lost_q <= '0;
    end
  end

  // R12
  rdy_needs_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !((ip_rdy && !ip_req) || (dp_rdy && !dp_req) || (xp_rdy && !xp_req)));

  // R5
  dp_beats_ip_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ip_rdy && dp_req) |-> (ip_bank != dp_bank));

  // R4
  split_banks_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ip_req && dp_req && (ip_bank != dp_bank) && !xp_req) |-> (ip_rdy && dp_rdy));

  // R6
  xp_yields_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (xp_rdy && (lost_q < LW'(MAX_WAIT))) |->
      !((dp_req && (dp_bank == xp_bank)) || (ip_req && (ip_bank == xp_bank))));

  // R7
  xp_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lost_q <= LW'(MAX_WAIT));

  // R7
  xp_due_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (xp_req && (lost_q == LW'(MAX_WAIT))) |-> xp_rdy);

endmodule

bind tcm_dual_bank tcm_dual_bank_chk #(.MAX_WAIT(XP_MAX_WAIT)) i_tcm_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .ip_req  (ip_req),
  .ip_rdy  (ip_rdy),
  .dp_req  (dp_req),
  .dp_rdy  (dp_rdy),
  .xp_req  (xp_req),
  .xp_rdy  (xp_rdy),
  .ip_bank (ip_addr[tcm_pkg::TCM_BANK_LSB +: tcm_pkg::TCM_BANK_W]),
  .dp_bank (dp_addr[tcm_pkg::TCM_BANK_LSB +: tcm_pkg::TCM_BANK_W]),
  .xp_bank (xp_addr[tcm_pkg::TCM_BANK_LSB +: tcm_pkg::TCM_BANK_W])
);

// File: tb/test_tcm_dual_bank.sv
`timescale 1ns/1ps
module test_tcm_dual_bank;

  logic        clk;
  logic        rst_n;
  logic        b_req  [3];
  logic        b_we   [3];
  logic [3:0]  b_be   [3];
  logic [15:0] b_addr [3];
  logic [31:0] b_wd   [3];
  logic        b_rdy  [3];
  logic [31:0] b_rd   [3];

  logic [31:0] ref_mem [4096];
  int n_vec = 0;
  int n_bad = 0;

  tcm_dual_bank i_tcm_dual_bank (
    .clk      (clk),
    .rst_n    (rst_n),
    .ip_req   (b_req[0]),
    .ip_addr  (b_addr[0]),
    .ip_rdy   (b_rdy[0]),
    .ip_rdata (b_rd[0]),
    .dp_req   (b_req[1]),
    .dp_we    (b_we[1]),
    .dp_be    (b_be[1]),
    .dp_addr  (b_addr[1]),
    .dp_wdata (b_wd[1]),
    .dp_rdy   (b_rdy[1]),
    .dp_rdata (b_rd[1]),
    .xp_req   (b_req[2]),
    .xp_we    (b_we[2]),
    .xp_be    (b_be[2]),
    .xp_addr  (b_addr[2]),
    .xp_wdata (b_wd[2]),
    .xp_rdy   (b_rdy[2]),
    .xp_rdata (b_rd[2])
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  function automatic int widx(input logic [15:0] a);
    return int'(a[13:2]);
  endfunction

  task automatic chk(input string rq, input logic [31:0] got, input logic [31:0] exp);
    n_vec++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", rq, got, exp);
    end
  endtask

  task automatic ref_write(input logic [15:0] a, input logic [3:0] be, input logic [31:0] d);
    for (int i = 0; i < 4; i++) begin
      if (be[i]) ref_mem[widx(a)][8*i +: 8] = d[8*i +: 8];
    end
  endtask

  // Entered at a falling edge; returns at the falling edge after the grant
  task automatic access(input int p, input logic w, input logic [3:0] be,
                        input logic [15:0] a, input logic [31:0] d, output logic [31:0] q);
    b_req[p] = 1'b1; b_we[p] = w; b_be[p] = be; b_addr[p] = a; b_wd[p] = d;
    #1;
    while (b_rdy[p] !== 1'b1) begin
      @(negedge clk); #1;
    end
    if (w) ref_write(a, be, d);
    @(negedge clk);
    b_req[p] = 1'b0; b_we[p] = 1'b0;
    q = b_rd[p];
  endtask

  task automatic wr(input int p, input logic [3:0] be, input logic [15:0] a, input logic [31:0] d);
    logic [31:0] q;
    access(p, 1'b1, be, a, d, q);
  endtask

  task automatic rd_chk(input int p, input logic [15:0] a, input string rq);
    logic [31:0] q;
    access(p, 1'b0, 4'hF, a, 32'h0, q);
    chk(rq, q, ref_mem[widx(a)]);
  endtask

  task automatic t_reset;
    chk("R1 ready outputs after reset", {29'b0, b_rdy[2], b_rdy[1], b_rdy[0]}, 32'h0);
    @(negedge clk); #1;
    chk("R12 no ready without request", {29'b0, b_rdy[2], b_rdy[1], b_rdy[0]}, 32'h0);
    @(negedge clk);
  endtask

  task automatic t_bank_map;
    wr(1, 4'hF, 16'h8000, 32'hA0A0_0001);
    wr(1, 4'hF, 16'hA000, 32'hB1B1_0002);
    rd_chk(1, 16'h8000, "R2 bank 0 word 0");
    rd_chk(1, 16'hA000, "R2 bank 1 word 0 distinct");
    rd_chk(0, 16'h4000, "R2 bit 14 aliases in fetch view");
    rd_chk(1, 16'hC003, "R2 bits 14 and 1:0 ignored in data view");
  endtask

  task automatic t_alias;
    wr(1, 4'hF, 16'h8124, 32'hC0DE_1234);
    rd_chk(0, 16'h0124, "R3 data write seen by fetch");
  endtask

  task automatic t_xp_view;
    wr(2, 4'hF, 16'h0330, 32'hD00D_0330);
    rd_chk(1, 16'h8330, "R8 external fetch-view write seen by data port");
    wr(2, 4'hF, 16'hA340, 32'hE00E_0340);
    rd_chk(0, 16'h2340, "R8 external data-view write seen by fetch");
    rd_chk(2, 16'h2340, "R8 external reads other view of same word");
  endtask

  task automatic t_bytes;
    wr(1, 4'hF, 16'h8400, 32'h1122_3344);
    wr(1, 4'b0101, 16'h8400, 32'hAABB_CCDD);
    rd_chk(0, 16'h0400, "R10 lanes 0 and 2 written");
    chk("R10 merged value", ref_mem[widx(16'h0400)], 32'h11BB_33DD);
    wr(2, 4'b1000, 16'h0400, 32'hEE00_0000);
    rd_chk(1, 16'h8400, "R10 top lane only");
  endtask

  task automatic t_parallel;
    wr(1, 4'hF, 16'h8010, 32'hF0F0_0010);
    wr(1, 4'hF, 16'hA010, 32'hF1F1_2010);
    b_req[0] = 1'b1; b_addr[0] = 16'h0010;
    b_req[1] = 1'b1; b_we[1] = 1'b0; b_addr[1] = 16'hA010;
    #1;
    chk("R4 fetch ready bank 0", {31'b0, b_rdy[0]}, 32'h1);
    chk("R4 data ready bank 1", {31'b0, b_rdy[1]}, 32'h1);
    @(negedge clk);
    b_req[0] = 1'b0; b_req[1] = 1'b0;
    chk("R9 fetch data next cycle", b_rd[0], 32'hF0F0_0010);
    chk("R9 data read next cycle", b_rd[1], 32'hF1F1_2010);
    b_req[0] = 1'b1; b_addr[0] = 16'h2010;
    b_req[1] = 1'b1; b_we[1] = 1'b1; b_be[1] = 4'hF; b_addr[1] = 16'h8010; b_wd[1] = 32'h5A5A_0010;
    #1;
    chk("R4 write bank 0 with fetch bank 1", {30'b0, b_rdy[1], b_rdy[0]}, 32'h3);
    ref_write(16'h8010, 4'hF, 32'h5A5A_0010);
    @(negedge clk);
    b_req[0] = 1'b0; b_req[1] = 1'b0; b_we[1] = 1'b0;
    chk("R9 fetch bank 1 during write", b_rd[0], 32'hF1F1_2010);
    rd_chk(1, 16'h8010, "R4 parallel write landed");
  endtask

  task automatic t_conflict;
    b_req[0] = 1'b1; b_addr[0] = 16'h0010;
    b_req[1] = 1'b1; b_we[1] = 1'b1; b_be[1] = 4'hF; b_addr[1] = 16'h8010; b_wd[1] = 32'h6B6B_0010;
    #1;
    chk("R5 data wins same bank", {30'b0, b_rdy[1], b_rdy[0]}, 32'h2);
    ref_write(16'h8010, 4'hF, 32'h6B6B_0010);
    @(negedge clk);
    b_req[1] = 1'b0; b_we[1] = 1'b0;
    #1;
    chk("R5 fetch served next", {31'b0, b_rdy[0]}, 32'h1);
    @(negedge clk);
    b_req[0] = 1'b0;
    chk("R5 fetch sees data write", b_rd[0], 32'h6B6B_0010);
  endtask

  task automatic t_xp_yield;
    b_req[1] = 1'b1; b_we[1] = 1'b0; b_addr[1] = 16'hA010;
    b_req[2] = 1'b1; b_we[2] = 1'b0; b_addr[2] = 16'h2010;
    #1;
    chk("R6 external loses to data", {30'b0, b_rdy[2], b_rdy[1]}, 32'h1);
    @(negedge clk);
    b_req[1] = 1'b0;
    #1;
    chk("R6 external granted on free bank", {31'b0, b_rdy[2]}, 32'h1);
    @(negedge clk);
    b_req[2] = 1'b0;
    chk("R6 external read data", b_rd[2], ref_mem[widx(16'h2010)]);
    b_req[0] = 1'b1; b_addr[0] = 16'h0010;
    b_req[2] = 1'b1; b_addr[2] = 16'h2010;
    #1;
    chk("R6 external alongside fetch on other bank", {30'b0, b_rdy[2], b_rdy[0]}, 32'h3);
    @(negedge clk);
    b_req[0] = 1'b0; b_req[2] = 1'b0;
    b_req[0] = 1'b1; b_addr[0] = 16'h0010;
    b_req[2] = 1'b1; b_addr[2] = 16'h8010;
    #1;
    chk("R6 external loses to fetch", {30'b0, b_rdy[2], b_rdy[0]}, 32'h1);
    @(negedge clk);
    b_req[0] = 1'b0;
    #1;
    chk("R6 external after fetch", {31'b0, b_rdy[2]}, 32'h1);
    @(negedge clk);
    b_req[2] = 1'b0;
  endtask

  task automatic t_starve;
    b_req[1] = 1'b1; b_we[1] = 1'b0; b_addr[1] = 16'h8010;
    b_req[2] = 1'b1; b_we[2] = 1'b0; b_addr[2] = 16'h0010;
    for (int k = 1; k <= 5; k++) begin
      #1;
      if (k < 5)
        chk($sformatf("R7 cycle %0d data keeps bank", k), {30'b0, b_rdy[2], b_rdy[1]}, 32'h1);
      else
        chk("R7 fifth cycle external overrides data", {30'b0, b_rdy[2], b_rdy[1]}, 32'h2);
      @(negedge clk);
    end
    b_req[2] = 1'b0;
    chk("R7 overdue read data", b_rd[2], ref_mem[widx(16'h0010)]);
    #1;
    chk("R7 data resumes", {31'b0, b_rdy[1]}, 32'h1);
    @(negedge clk);
    b_req[1] = 1'b0;
  endtask

  task automatic t_random;
    logic        pend  [3];
    logic        gdone [3];
    logic [31:0] exp_q [3];
    int          lost;
    lost = 0;
    for (int i = 0; i < 64; i++) begin
      wr(1, 4'hF, 16'h8000 | 16'((i / 32) << 13) | 16'((i % 32) << 2), $urandom);
    end
    for (int p = 0; p < 3; p++) begin pend[p] = 1'b0; gdone[p] = 1'b0; end
    for (int c = 0; c < 3000; c++) begin
      @(negedge clk);
      for (int p = 0; p < 3; p++) begin
        if (pend[p]) chk($sformatf("R11 random read port %0d", p), b_rd[p], exp_q[p]);
        pend[p] = 1'b0;
        if (gdone[p]) begin b_req[p] = 1'b0; b_we[p] = 1'b0; end
        if (!b_req[p] && ($urandom % 2 == 1)) begin
          int idx;
          logic [15:0] a;
          idx = $urandom % 64;
          a = 16'((idx / 32) << 13) | 16'((idx % 32) << 2) | 16'(($urandom % 2) << 14);
          if (p == 1) a = a | 16'h8000;
          if (p == 2) a = a | 16'(($urandom % 2) << 15);
          b_req[p] = 1'b1; b_addr[p] = a;
          b_we[p]  = (p != 0) && ($urandom % 2 == 1);
          b_be[p]  = 4'($urandom % 15 + 1);
          b_wd[p]  = $urandom;
        end
      end
      #1;
      for (int p = 0; p < 3; p++) begin
        gdone[p] = b_req[p] && b_rdy[p];
        if (gdone[p] && !b_we[p]) begin pend[p] = 1'b1; exp_q[p] = ref_mem[widx(b_addr[p])]; end
      end
      for (int p = 0; p < 3; p++) begin
        if (gdone[p] && b_we[p]) ref_write(b_addr[p], b_be[p], b_wd[p]);
      end
      if (b_req[2] && !b_rdy[2]) lost++;
      else begin
        if (gdone[2]) chk("R7 random external wait bound", {31'b0, lost <= 4}, 32'h1);
        lost = 0;
      end
    end
    @(negedge clk);
    for (int p = 0; p < 3; p++) begin
      if (pend[p]) chk($sformatf("R11 random read port %0d", p), b_rd[p], exp_q[p]);
      b_req[p] = 1'b0; b_we[p] = 1'b0;
    end
    @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_vec++; n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    for (int p = 0; p < 3; p++) begin
      b_req[p] = 1'b0; b_we[p] = 1'b0; b_be[p] = 4'hF; b_addr[p] = 16'h0; b_wd[p] = 32'h0;
    end
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    t_reset;
    t_bank_map;
    t_alias;
    t_xp_view;
    t_bytes;
    t_parallel;
    t_conflict;
    t_xp_yield;
    t_starve;
    t_random;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

endmodule